// File: doc/BRIEF.md
# Debug Memory Access Port

This block sits behind a debug port and turns debugger register accesses into single 32-bit transfers on an AHB-Lite style bus master. Each request carries a flag that picks the access-port or the debug-port side, a two-bit register offset, a direction and 32 bits of write data. On the debug-port side the block keeps the bank select register and serves the read buffer. On the access-port side it keeps a control/status word, a transfer address and a data window. An access to the data window launches one bus transfer at the transfer address.

Access-port reads are posted. A read returns the value captured by the previous access-port read, and its own result is captured for the next read. The debug-port read buffer returns that captured value without starting anything. While a bus transfer is outstanding, every request is held off by a wait signal.

Top module: `mem_access_port`

## Requirements
- R1: After reset, respWait, respValid and htrans (IDLE = 2'b00) are low. The control/status word, the transfer address, the bank and the posted result are zero, so the first access-port read returns 0.
- R2: A debug-port write (reqApSel=0) to offset 2 loads the bank from reqWdata[7:4]. The access-port word index is {bank, reqAddr}. With a nonzero bank, access-port reads capture 0 and access-port writes change nothing, including the data window, which starts no bus transfer.
- R3: In bank 0, offset 0 is the control/status word. Its writable fields are size [1:0] (0 byte, 1 halfword, 2 or 3 word), increment mode [5:4] (01 increment-single, anything else none) and protection [27:24]. Bit 7 is busy and every other bit reads 0. Offset 1 is the transfer address. Offset 2 reads 0 and ignores writes.
- R4: Every access-port read returns the value captured by the preceding access-port read. A register read captures the register value. A data window read (offset 3) captures the bus read result.
- R5: A debug-port read at offset 3 returns the captured value. It changes that value and the registers in no way and starts no bus transfer. Debug-port reads at other offsets return 0.
- R6: A data window write makes exactly one bus write with htrans NONSEQ (2'b10) for one cycle, then IDLE. The transfer drives haddr equal to the transfer address, hsize 0/1/2 matching the size field and hprot from the protection field. hwdata carries the data shifted onto its lane: a byte goes to lane addr[1:0], a halfword to lane addr[1], a word takes all 32 bits.
- R7: A data window read makes one bus read at the transfer address. The block captures hrdata shifted down from the same lane, masked to the transfer size and zero-extended.
- R8: In increment-single mode the transfer address grows by 1, 2 or 4 bytes after each completed data window transfer. In other modes it stays unchanged.
- R9: A data window access raises respWait from the cycle after acceptance until the bus completes. That is one address cycle plus the data cycles up to and including the one with hready high. No request is accepted while respWait is high.
- R10: An accepted read pulses respValid in the next cycle with respRdata. An accepted write produces no respValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; accepted when respWait is low |
| reqApSel | input | 1 | 1 = access-port register, 0 = debug-port register |
| reqAddr | input | 2 | Register offset within the four-word window |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write data |
| respWait | output | 1 | Request stall while a bus transfer is outstanding |
| respValid | output | 1 | Read data valid pulse |
| respRdata | output | 32 | Read data |
| haddr | output | 32 | Bus address |
| htrans | output | 2 | Bus transfer type (IDLE or NONSEQ) |
| hwrite | output | 1 | Bus direction |
| hsize | output | 3 | Bus transfer size |
| hprot | output | 4 | Bus protection |
| hwdata | output | 32 | Bus write data |
| hrdata | input | 32 | Bus read data |
| hready | input | 1 | Bus transfer complete |

## Verification
When a data window read completes, three things land on the same clock edge: the bus read result goes into the posted holding register, the transfer address steps by the transfer size, and respWait falls. The bench provokes this by sweeping size, increment mode, low address offset and wait-state count. Right after each transfer it reads the transfer address back through the posted path and reads the read buffer. It judges against arithmetically computed lane contents, address steps and stall lengths. It also checks that the data returned with the data window read is the earlier posted value and not the new bus data.

// File: rtl/memApPkg.sv
package memApPkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} apState_e;

  typedef struct packed {
    logic wrCsw;
    logic wrTar;
    logic wrSel;
    logic rdAp;
    logic rdDp;
    logic startBus;
    logic busWrite;
    logic busDone;
  } apStrobe_t;
endpackage

// File: rtl/memApCtrl.sv
module memApCtrl
  import memApPkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqApSel,
  input  logic [1:0]        reqAddr,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] bank,
  input  logic              hready,
  output apStrobe_t         strb,
  output logic              respWait,
  output logic              addrPhase
);
  apState_e state, stateNext;
  logic accept;
  logic bankZero;

  assign accept   = reqValid && (state == ST_IDLE);
  assign bankZero = (bank == '0);

  always_comb begin
    strb = '0;
    if (accept) begin
      if (reqApSel) begin
        if (reqWrite) begin
          strb.wrCsw = bankZero && (reqAddr == 2'd0);
          strb.wrTar = bankZero && (reqAddr == 2'd1);
        end else begin
          strb.rdAp = 1'b1;
        end
        strb.startBus = bankZero && (reqAddr == 2'd3);
        strb.busWrite = reqWrite;
      end else begin
        strb.wrSel = reqWrite && (reqAddr == 2'd2);
        strb.rdDp  = !reqWrite;
      end
    end
    strb.busDone = (state == ST_DATA) && hready;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strb.startBus) stateNext = ST_ADDR;
      ST_ADDR: stateNext = ST_DATA;
      ST_DATA: if (hready) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign respWait  = (state != ST_IDLE);
  assign addrPhase = (state == ST_ADDR);
endmodule

// File: rtl/memApDatapath.sv
module memApDatapath
  import memApPkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  apStrobe_t         strb,
  input  logic [1:0]        reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              busy,
  input  logic              addrPhase,
  input  logic [DATA_W-1:0] hrdata,
  output logic [BANK_W-1:0] bank,
  output logic              respValid,
  output logic [DATA_W-1:0] respRdata,
  output logic [DATA_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [3:0]        hprot,
  output logic [DATA_W-1:0] hwdata
);
  localparam int SHIFT_W = $clog2(DATA_W);

  logic [1:0]        cswSize;
  logic [1:0]        cswInc;
  logic [3:0]        cswProt;
  logic [DATA_W-1:0] tar;
  logic [DATA_W-1:0] wrData;
  logic              busWrite;
  logic [DATA_W-1:0] posted;

  logic [DATA_W-1:0] cswWord;
  logic [DATA_W-1:0] apRegVal;
  logic [DATA_W-1:0] sizeMask;
  logic [DATA_W-1:0] incBytes;
  logic [DATA_W-1:0] rdLane;
  logic [SHIFT_W-1:0] laneShift;

  always_comb begin
    unique case (cswSize)
      2'd0:    hsize = 3'd0;
      2'd1:    hsize = 3'd1;
      default: hsize = 3'd2;
    endcase
  end

  always_comb begin
    laneShift = '0;
    sizeMask  = '1;
    if (hsize == 3'd0) begin
      laneShift = SHIFT_W'({tar[1:0], 3'b000});
      sizeMask  = DATA_W'(32'h0000_00FF);
    end else if (hsize == 3'd1) begin
      laneShift = SHIFT_W'({tar[1], 4'b0000});
      sizeMask  = DATA_W'(32'h0000_FFFF);
    end
  end

  assign incBytes = DATA_W'(1) << hsize;
  assign rdLane   = (hrdata >> laneShift) & sizeMask;
  assign cswWord  = {4'b0, cswProt, 16'b0, busy, 1'b0, cswInc, 2'b0, cswSize};

  always_comb begin
    apRegVal = '0;
    if (bank == '0) begin
      if (reqAddr == 2'd0)      apRegVal = cswWord;
      else if (reqAddr == 2'd1) apRegVal = tar;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cswSize   <= '0;
      cswInc    <= '0;
      cswProt   <= '0;
      tar       <= '0;
      bank      <= '0;
      wrData    <= '0;
      busWrite  <= 1'b0;
      posted    <= '0;
      respValid <= 1'b0;
      respRdata <= '0;
    end else begin
      respValid <= strb.rdAp || strb.rdDp;
      if (strb.wrCsw) begin
        cswSize <= reqWdata[1:0];
        cswInc  <= reqWdata[5:4];
        cswProt <= reqWdata[27:24];
      end
      if (strb.wrTar) tar  <= reqWdata;
      if (strb.wrSel) bank <= reqWdata[4 +: BANK_W];
      if (strb.rdAp) begin
        respRdata <= posted;
        if (!strb.startBus) posted <= apRegVal;
      end
      if (strb.rdDp) respRdata <= (reqAddr == 2'd3) ? posted : '0;
      if (strb.startBus) begin
        wrData   <= reqWdata;
        busWrite <= strb.busWrite;
      end
      if (strb.busDone) begin
        if (!busWrite) posted <= rdLane;
        if (cswInc == 2'b01) tar <= tar + incBytes;
      end
    end
  end

  assign haddr  = tar;
  assign htrans = addrPhase ? 2'b10 : 2'b00;
  assign hwrite = busWrite;
  assign hprot  = cswProt;
  assign hwdata = (wrData & sizeMask) << laneShift;
endmodule

// File: rtl/mem_access_port.sv
module mem_access_port
  import memApPkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqApSel,
  input  logic [1:0]        reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              respWait,
  output logic              respValid,
  output logic [DATA_W-1:0] respRdata,
  output logic [DATA_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [3:0]        hprot,
  output logic [DATA_W-1:0] hwdata,
  input  logic [DATA_W-1:0] hrdata,
  input  logic              hready
);
  apStrobe_t         strb;
  logic              addrPhase;
  logic [BANK_W-1:0] bank;

  memApCtrl #(.BANK_W(BANK_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqApSel(reqApSel),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .bank(bank), .hready(hready),
    .strb(strb), .respWait(respWait), .addrPhase(addrPhase)
  );

  memApDatapath #(.BANK_W(BANK_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busy(respWait), .addrPhase(addrPhase), .hrdata(hrdata), .bank(bank),
    .respValid(respValid), .respRdata(respRdata), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hprot(hprot), .hwdata(hwdata)
  );
endmodule

// File: rtl/memApChecker.sv
module memApChecker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic        respWait,
  input logic        respValid,
  input logic [1:0]  htrans,
  input logic        hready,
  input logic [31:0] haddr,
  input logic [2:0]  hsize
);
  a_r9_wait_in_addr: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b10) |-> respWait);

  a_r6_single_nonseq: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b10) |=> (htrans == 2'b00));

  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (respWait && !hready && htrans == 2'b00) |=> $stable(haddr));

  a_r10_write_silent: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !respWait && reqWrite) |=> !respValid);

  a_r10_read_resp: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !respWait && !reqWrite) |=> respValid);

  a_r6_size_legal: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b10) |-> (hsize <= 3'd2));
endmodule

bind mem_access_port memApChecker i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .respWait(respWait), .respValid(respValid), .htrans(htrans),
  .hready(hready), .haddr(haddr), .hsize(hsize)
);

// File: tb/test_mem_access_port.sv
`timescale 1ns/1ps
module test_mem_access_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqApSel = 1'b0;
  logic [1:0]  reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        respWait, respValid;
  logic [31:0] respRdata, haddr, hwdata;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize;
  logic [3:0]  hprot;
  logic [31:0] hrdata = '0;
  logic        hready = 1'b1;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int          xferCount = 0;
  int          waitCfg = 0;
  int          remain = 0;
  bit          inData = 0;
  logic [31:0] lastAddr, lastHwdata;
  logic        lastWrite;
  logic [2:0]  lastSize;
  logic [3:0]  lastProt;

  always #2 clk = ~clk;

  mem_access_port i_mem_access_port (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqApSel(reqApSel),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .respWait(respWait), .respValid(respValid), .respRdata(respRdata),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .hprot(hprot), .hwdata(hwdata), .hrdata(hrdata), .hready(hready)
  );

  function automatic logic [31:0] rdPat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
  endfunction

  // bus slave model, driven away from the active edge
  always @(negedge clk) begin
    if (inData) begin
      if (remain == 0) begin
        hready     = 1'b1;
        hrdata     = rdPat(lastAddr);
        lastHwdata = hwdata;
        inData     = 0;
      end else begin
        remain = remain - 1;
        hready = 1'b0;
      end
    end else begin
      hready = 1'b1;
    end
    if (htrans == 2'b10) begin
      xferCount = xferCount + 1;
      lastAddr  = haddr;
      lastWrite = hwrite;
      lastSize  = hsize;
      lastProt  = hprot;
      remain    = waitCfg;
      inData    = 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apReq(input logic ap, input logic [1:0] a, input logic wr,
                       input logic [31:0] wd, output logic [31:0] rd, output int busyCycles);
    @(negedge clk);
    while (respWait) @(negedge clk);
    reqValid = 1'b1; reqApSel = ap; reqAddr = a; reqWrite = wr; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    rd = respRdata;
    chk("R10 respValid after request", {31'b0, respValid}, {31'b0, !wr});
    busyCycles = 0;
    while (respWait) begin
      busyCycles++;
      @(negedge clk);
    end
  endtask

  logic [31:0] rd;
  int          bc;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 respWait", {31'b0, respWait}, 32'd0);
    chk("R1 respValid", {31'b0, respValid}, 32'd0);
    chk("R1 htrans", {30'b0, htrans}, 32'd0);

    apReq(1, 2'd0, 0, 0, rd, bc);
    chk("R1 first posted read", rd, 32'd0);
    apReq(1, 2'd0, 1, 32'hFFFF_FFFF, rd, bc);
    apReq(1, 2'd1, 0, 0, rd, bc);
    chk("R4 returns earlier csw capture", rd, 32'd0);
    apReq(1, 2'd0, 0, 0, rd, bc);
    chk("R4 returns tar capture", rd, 32'd0);
    apReq(0, 2'd3, 0, 0, rd, bc);
    chk("R3 csw field readback", rd, 32'h0F00_0033);
    apReq(0, 2'd3, 0, 0, rd, bc);
    chk("R5 read buffer repeat", rd, 32'h0F00_0033);
    apReq(0, 2'd1, 0, 0, rd, bc);
    chk("R5 other dp offset reads zero", rd, 32'd0);
    apReq(1, 2'd2, 1, 32'h1234_5678, rd, bc);
    apReq(1, 2'd2, 0, 0, rd, bc);
    apReq(0, 2'd3, 0, 0, rd, bc);
    chk("R3 offset 2 reads zero", rd, 32'd0);
    chk("R5 no bus transfer yet", xferCount, 0);

    // R2 banking
    apReq(1, 2'd1, 1, 32'h0000_0100, rd, bc);
    apReq(0, 2'd2, 1, 32'h0000_0010, rd, bc);
    apReq(1, 2'd0, 1, 32'h0000_0000, rd, bc);
    apReq(1, 2'd3, 1, 32'hDEAD_BEEF, rd, bc);
    apReq(1, 2'd3, 0, 0, rd, bc);
    chk("R2 bank1 data window starts no bus", xferCount, 0);
    apReq(1, 2'd1, 0, 0, rd, bc);
    apReq(0, 2'd3, 0, 0, rd, bc);
    chk("R2 bank1 read captures zero", rd, 32'd0);
    apReq(0, 2'd2, 1, 32'h0000_0000, rd, bc);
    apReq(1, 2'd0, 0, 0, rd, bc);
    apReq(0, 2'd3, 0, 0, rd, bc);
    chk("R2 bank1 write ignored csw", rd, 32'h0F00_0033);
    apReq(1, 2'd1, 0, 0, rd, bc);
    apReq(0, 2'd3, 0, 0, rd, bc);
    chk("R2 tar after bank1 writes", rd, 32'h0000_0100);

    // sweep size, increment mode, offset, wait states
    for (int it = 0; it < 48; it++) begin
      int sz = it % 3;
      int inc = (it / 3) % 2;
      int off = (it / 6) % 4;
      int wc = ((it / 24) % 2) * 2;
      logic [3:0]  prot = 4'(sz * 2 + inc) ^ 4'h5;
      logic [31:0] cswW = {4'b0, prot, 16'b0, 2'b0, 2'(inc), 2'b0, 2'(sz)};
      logic [31:0] tarV = 32'h2000_0040 + 32'(it * 16) + 32'(off);
      logic [31:0] wd = 32'hC3A5_1E96 ^ (32'(it) * 32'h0101_0203);
      int          sh = (sz == 0) ? off * 8 : (sz == 1) ? (off / 2) * 16 : 0;
      logic [31:0] msk = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
      logic [31:0] expTar = (inc == 1) ? tarV + (32'd1 << sz) : tarV;
      int          cnt0;
      waitCfg = wc;
      apReq(1, 2'd0, 1, cswW, rd, bc);
      apReq(1, 2'd1, 1, tarV, rd, bc);
      cnt0 = xferCount;
      apReq(1, 2'd3, 1, wd, rd, bc);
      chk("R6 one transfer", xferCount, cnt0 + 1);
      chk("R6 haddr", lastAddr, tarV);
      chk("R6 hwrite", {31'b0, lastWrite}, 32'd1);
      chk("R6 hsize", {29'b0, lastSize}, 32'(sz));
      chk("R6 hprot", {28'b0, lastProt}, {28'b0, prot});
      chk("R6 hwdata lane", lastHwdata, (wd & msk) << sh);
      chk("R9 busy cycles", bc, wc + 2);
      apReq(1, 2'd1, 0, 0, rd, bc);
      apReq(0, 2'd3, 0, 0, rd, bc);
      chk("R8 address step", rd, expTar);
      apReq(1, 2'd1, 1, tarV, rd, bc);
      apReq(1, 2'd3, 0, 0, rd, bc);
      chk("R4 window read returns prior capture", rd, expTar);
      chk("R7 bus read address", lastAddr, tarV);
      chk("R7 bus read direction", {31'b0, lastWrite}, 32'd0);
      chk("R9 read busy cycles", bc, wc + 2);
      apReq(0, 2'd3, 0, 0, rd, bc);
      chk("R7 lane extract", rd, (rdPat(tarV) >> sh) & msk);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule